// File: doc/BRIEF.md
# ADC Conversion Scan Sequencer

This block is the digital controller in front of an eight-input successive-approximation converter. It takes its settings as plain inputs: a converter enable, a mode code, an eight-bit channel-enable mask, a differential-input switch, a signed-format switch, and the interrupt and DMA enables. Software requests a conversion with a one-cycle start pulse and can abort a running sequence with a one-cycle clear pulse. The state of the start flag is visible as an output. When hardware finishes a single conversion or a single pass, it clears the flag by itself.

For each conversion the sequencer sends the analog side a one-cycle start pulse together with a select code. It then waits for a done pulse that carries the raw 12-bit code. The result goes into the data register of the channel being served, and that register's valid flag is set. Reading the register clears the flag. In differential mode the select code names a channel pair rather than a single input. Each enabled channel of a pair gets its own conversion of that pair. Each completed result raises a one-cycle interrupt pulse or a one-cycle DMA pulse, depending on the enables.

Top module: `adc_scan_seq`

## Requirements
- R1: No conversion start is issued, and a start request is not taken, while the converter enable is 0.
- R2: Mode code 2'b00 converts only the lowest-index enabled channel, once. The start flag then returns to 0 without software action.
- R3: Mode code 2'b10 converts every enabled channel once, in ascending index order. The start flag clears after the highest enabled channel is converted.
- R4: Mode code 2'b11 keeps cycling through the enabled channels in ascending order, wrapping to the lowest. A clear pulse drops the start flag at once, lets the conversion in flight finish and be stored, and issues no further start.
- R5: Mode code 2'b01 is reserved. A start request in this mode leaves the start flag at 0 and issues no conversion.
- R6: With differential mode on, channel c is converted with select c/2 and the differential output high. The result is stored in channel c's register. When both channels of a pair are enabled, the pair is converted twice, with results in both registers.
- R7: With differential mode and the signed-format switch both on, the stored value is the raw code with bit 11 inverted. In every other case the stored value is the raw code.
- R8: Each stored result gives one interrupt pulse if the interrupt enable is 1 and the DMA enable is 0. If the DMA enable is 1, it gives one DMA pulse and no interrupt pulse.
- R9: A data register's valid flag is 0 after reset. A write sets it, and a read of that register clears it. A write in the same cycle as a read takes precedence.
- R10: At most one conversion is outstanding. A new start pulse follows only after the done pulse of the previous one.
- R11: A start request with an all-zero channel mask is ignored, and the start flag stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_en | input | 1 | Converter enable |
| cfg_irq_en | input | 1 | Interrupt pulse enable |
| cfg_mode | input | 2 | 00 single, 01 reserved, 10 one pass, 11 continuous |
| cfg_dma_en | input | 1 | DMA pulse enable (suppresses interrupt) |
| cfg_diff | input | 1 | Differential pair mode |
| cfg_twos | input | 1 | Signed storage format in differential mode |
| cfg_chan_mask | input | 8 | Channel enable mask, bit i for channel i |
| start_set | input | 1 | One-cycle start request |
| start_clr | input | 1 | One-cycle stop request |
| start_bit | output | 1 | Current state of the start flag |
| conv_start | output | 1 | One-cycle start pulse to the converter |
| conv_sel | output | 3 | Channel, or pair index in differential mode |
| conv_diff | output | 1 | Differential conversion request |
| conv_done | input | 1 | One-cycle done pulse from the converter |
| conv_code | input | 12 | Raw result code, valid with conv_done |
| rd_en | input | 1 | Read strobe, clears the addressed valid flag |
| rd_idx | input | 3 | Data register index to read |
| rd_data | output | 12 | Addressed data register |
| rd_valid | output | 1 | Addressed valid flag |
| eoc_irq | output | 1 | End-of-conversion interrupt pulse |
| dma_req | output | 1 | DMA request pulse |

## Verification
On every cycle, the embedded properties check the following: starts are gated by the enable and by a non-reserved mode, two start pulses never follow each other back to back, a pair select stays below four, the interrupt and DMA pulses never overlap, the single-mode start flag clears after a done, and the valid flags follow writes and reads. Other behaviour needs whole scenarios and is shown only by the bench. This covers the order of visited channels, the double conversion of a fully enabled pair, the stored values in signed and unsigned form, and the pulse counts per pass. It also covers the wrap and clean stop of continuous mode and the rejection of reserved-mode or empty-mask requests.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

  typedef enum logic [1:0] {
    MODE_ONE  = 2'b00,
    MODE_RSVD = 2'b01,
    MODE_PASS = 2'b10,
    MODE_LOOP = 2'b11
  } scan_mode_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_WAIT = 1'b1
  } seq_state_e;

endpackage

// File: rtl/adc_chan_picker.sv
// Finds the lowest enabled channel whose index is at or above a start point.
module adc_chan_picker #(
  parameter int unsigned NCH = 8,
  localparam int unsigned SEL_W = $clog2(NCH),
  localparam int unsigned PTR_W = SEL_W + 1
) (
  input  logic [NCH-1:0]   mask,
  input  logic [PTR_W-1:0] from,
  output logic             hit,
  output logic [SEL_W-1:0] idx
);

  logic [NCH-1:0] cand;

  for (genvar g = 0; g < NCH; g++) begin : g_cand
    assign cand[g] = mask[g] && (PTR_W'(g) >= from);
  end

  always_comb begin
    hit = 1'b0;
    idx = '0;
    for (int i = NCH - 1; i >= 0; i--) begin
      if (cand[i]) begin
        hit = 1'b1;
        idx = SEL_W'(i);
      end
    end
  end

endmodule

// File: rtl/adc_result_bank.sv
// Per-channel result registers with valid flags (set on write, cleared on read).
module adc_result_bank #(
  parameter int unsigned NCH = 8,
  parameter int unsigned RES_W = 12,
  localparam int unsigned SEL_W = $clog2(NCH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [SEL_W-1:0] wr_idx,
  input  logic [RES_W-1:0] wr_code,
  input  logic             wr_signed,
  input  logic             rd_en,
  input  logic [SEL_W-1:0] rd_idx,
  output logic [RES_W-1:0] rd_data,
  output logic             rd_valid
);

  // Offset-binary to two's complement: flip the top bit.
  function automatic logic [RES_W-1:0] stored_form(input logic [RES_W-1:0] code,
                                                   input logic sgn);
    return sgn ? {~code[RES_W-1], code[RES_W-2:0]} : code;
  endfunction

  logic [NCH-1:0][RES_W-1:0] data_q;
  logic [NCH-1:0]            vld_q;
  logic [RES_W-1:0]          wr_value;

  assign wr_value = stored_form(wr_code, wr_signed);

  for (genvar g = 0; g < NCH; g++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        data_q[g] <= '0;
        vld_q[g]  <= 1'b0;
      end else if (wr_en && wr_idx == SEL_W'(g)) begin
        data_q[g] <= wr_value;
        vld_q[g]  <= 1'b1;
      end else if (rd_en && rd_idx == SEL_W'(g)) begin
        vld_q[g]  <= 1'b0;
      end
    end
  end

  assign rd_data  = data_q[rd_idx];
  assign rd_valid = vld_q[rd_idx];

  a_r9_write_sets_valid: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> vld_q[$past(wr_idx)]);

  a_r9_read_clears_valid: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !(wr_en && wr_idx == rd_idx)) |=> !vld_q[$past(rd_idx)]);

endmodule

// File: rtl/adc_scan_seq.sv
module adc_scan_seq
  import adc_seq_pkg::*;
#(
  parameter int unsigned NCH = 8,
  parameter int unsigned RES_W = 12,
  localparam int unsigned SEL_W = $clog2(NCH),
  localparam int unsigned PTR_W = SEL_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_en,
  input  logic             cfg_irq_en,
  input  logic [1:0]       cfg_mode,
  input  logic             cfg_dma_en,
  input  logic             cfg_diff,
  input  logic             cfg_twos,
  input  logic [NCH-1:0]   cfg_chan_mask,
  input  logic             start_set,
  input  logic             start_clr,
  output logic             start_bit,
  output logic             conv_start,
  output logic [SEL_W-1:0] conv_sel,
  output logic             conv_diff,
  input  logic             conv_done,
  input  logic [RES_W-1:0] conv_code,
  input  logic             rd_en,
  input  logic [SEL_W-1:0] rd_idx,
  output logic [RES_W-1:0] rd_data,
  output logic             rd_valid,
  output logic             eoc_irq,
  output logic             dma_req
);

  scan_mode_e mode;
  seq_state_e state_q;
  logic             run_q;
  logic [SEL_W-1:0] cur_ch_q;
  logic             first_hit, next_hit;
  logic [SEL_W-1:0] first_idx, next_idx;
  logic [PTR_W-1:0] next_from;

  // Named internal events, used by the assertions below.
  logic             mode_ok;
  logic             accept_req;
  logic             done_evt;
  logic             continue_issue;
  logic             issue_idle;
  logic             issue;
  logic [SEL_W-1:0] issue_ch;
  logic             auto_clr;

  assign mode      = scan_mode_e'(cfg_mode);
  assign mode_ok   = (mode != MODE_RSVD);
  assign next_from = PTR_W'(cur_ch_q) + PTR_W'(1);

  adc_chan_picker #(.NCH(NCH)) u_first (
    .mask(cfg_chan_mask), .from('0), .hit(first_hit), .idx(first_idx)
  );

  adc_chan_picker #(.NCH(NCH)) u_next (
    .mask(cfg_chan_mask), .from(next_from), .hit(next_hit), .idx(next_idx)
  );

  assign accept_req = start_set && cfg_en && mode_ok && first_hit;
  assign done_evt   = (state_q == ST_WAIT) && conv_done;

  always_comb begin
    continue_issue = 1'b0;
    if (run_q && !start_clr && cfg_en) begin
      unique case (mode)
        MODE_PASS: continue_issue = next_hit;
        MODE_LOOP: continue_issue = next_hit || first_hit;
        default:   continue_issue = 1'b0;
      endcase
    end
  end

  assign issue_idle = (state_q == ST_IDLE) && run_q && !start_clr
                      && cfg_en && mode_ok && first_hit;
  assign issue      = issue_idle || (done_evt && continue_issue);
  assign issue_ch   = (issue_idle || !next_hit) ? first_idx : next_idx;
  assign auto_clr   = done_evt && !continue_issue;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
    end else if (start_clr || auto_clr) begin
      run_q <= 1'b0;
    end else if (accept_req) begin
      run_q <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      cur_ch_q   <= '0;
      conv_start <= 1'b0;
      conv_sel   <= '0;
      conv_diff  <= 1'b0;
      eoc_irq    <= 1'b0;
      dma_req    <= 1'b0;
    end else begin
      conv_start <= issue;
      eoc_irq    <= done_evt && cfg_irq_en && !cfg_dma_en;
      dma_req    <= done_evt && cfg_dma_en;
      if (issue) begin
        state_q   <= ST_WAIT;
        cur_ch_q  <= issue_ch;
        conv_sel  <= cfg_diff ? (issue_ch >> 1) : issue_ch;
        conv_diff <= cfg_diff;
      end else if (done_evt) begin
        state_q   <= ST_IDLE;
      end
    end
  end

  assign start_bit = run_q;

  adc_result_bank #(.NCH(NCH), .RES_W(RES_W)) u_bank (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (done_evt),
    .wr_idx    (cur_ch_q),
    .wr_code   (conv_code),
    .wr_signed (conv_diff && cfg_twos),
    .rd_en     (rd_en),
    .rd_idx    (rd_idx),
    .rd_data   (rd_data),
    .rd_valid  (rd_valid)
  );

  a_r1_start_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |-> $past(cfg_en));

  a_r5_reserved_no_start: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |-> ($past(cfg_mode) != 2'b01));

  a_r10_no_back_to_back: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |=> !conv_start);

  a_r10_wait_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_WAIT && !conv_done) |=> !conv_start);

  a_r6_pair_select: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_start && conv_diff) |-> (conv_sel < SEL_W'(NCH / 2)));

  a_r8_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(eoc_irq && dma_req));

  a_r8_irq_gated: assert property (@(posedge clk) disable iff (!rst_n)
    eoc_irq |-> $past(cfg_irq_en && !cfg_dma_en));

  a_r2_single_autoclear: assert property (@(posedge clk) disable iff (!rst_n)
    (done_evt && cfg_mode == 2'b00) |=> !start_bit);

endmodule

// File: tb/adc_scan_seq_bench.sv
`timescale 1ns/1ps
module adc_scan_seq_bench;

  localparam int LAT = 4;
  localparam int NV  = 8;
  // {mode[17:16], diff[15], twos[14], irq[13], dma[12], mask[11:4], n_conv[3:0]}
  localparam logic [17:0] VEC [NV] = '{
    {2'b00, 1'b0, 1'b0, 1'b1, 1'b0, 8'h24, 4'd1},
    {2'b10, 1'b0, 1'b0, 1'b1, 1'b0, 8'hA5, 4'd4},
    {2'b10, 1'b1, 1'b1, 1'b0, 1'b1, 8'h03, 4'd2},
    {2'b10, 1'b1, 1'b0, 1'b1, 1'b1, 8'h84, 4'd2},
    {2'b01, 1'b0, 1'b0, 1'b1, 1'b0, 8'hFF, 4'd0},
    {2'b10, 1'b0, 1'b0, 1'b1, 1'b0, 8'h00, 4'd0},
    {2'b00, 1'b1, 1'b1, 1'b1, 1'b0, 8'h80, 4'd1},
    {2'b10, 1'b0, 1'b0, 1'b0, 1'b0, 8'hFF, 4'd8}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_en = 1'b0, cfg_irq_en = 1'b0, cfg_dma_en = 1'b0;
  logic cfg_diff = 1'b0, cfg_twos = 1'b0;
  logic [1:0] cfg_mode = 2'b00;
  logic [7:0] cfg_chan_mask = 8'h00;
  logic start_set = 1'b0, start_clr = 1'b0;
  logic start_bit, conv_start, conv_diff;
  logic [2:0] conv_sel;
  logic conv_done = 1'b0;
  logic [11:0] conv_code = 12'h000;
  logic rd_en = 1'b0;
  logic [2:0] rd_idx = 3'd0;
  logic [11:0] rd_data;
  logic rd_valid, eoc_irq, dma_req;

  int errors = 0;
  int checks = 0;
  int n_starts = 0, irq_cnt = 0, dma_cnt = 0, lat_cnt = 0;
  logic [2:0] log_sel [32];
  logic       log_diff [32];
  logic [2:0] held_sel = 3'd0;
  logic       held_diff = 1'b0;

  always #2.5 clk = ~clk;

  adc_scan_seq u_adc_scan_seq (
    .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_irq_en(cfg_irq_en),
    .cfg_mode(cfg_mode), .cfg_dma_en(cfg_dma_en), .cfg_diff(cfg_diff),
    .cfg_twos(cfg_twos), .cfg_chan_mask(cfg_chan_mask), .start_set(start_set),
    .start_clr(start_clr), .start_bit(start_bit), .conv_start(conv_start),
    .conv_sel(conv_sel), .conv_diff(conv_diff), .conv_done(conv_done),
    .conv_code(conv_code), .rd_en(rd_en), .rd_idx(rd_idx), .rd_data(rd_data),
    .rd_valid(rd_valid), .eoc_irq(eoc_irq), .dma_req(dma_req)
  );

  function automatic logic [11:0] raw_of(input logic [2:0] sel, input logic dif);
    return 12'hA00 | (dif ? 12'h010 : 12'h000) | {9'd0, sel};
  endfunction

  function automatic logic [11:0] expect_store(input logic [11:0] raw, input logic sgn);
    return sgn ? (raw ^ 12'h800) : raw;
  endfunction

  // Converter model: fixed latency, driven and observed on the falling edge.
  always @(negedge clk) begin
    conv_done = 1'b0;
    if (lat_cnt > 0) begin
      lat_cnt = lat_cnt - 1;
      if (lat_cnt == 0) begin
        conv_done = 1'b1;
        conv_code = raw_of(held_sel, held_diff);
      end
    end
    if (rst_n && conv_start) begin
      held_sel  = conv_sel;
      held_diff = conv_diff;
      lat_cnt   = LAT;
      if (n_starts < 32) begin
        log_sel[n_starts]  = conv_sel;
        log_diff[n_starts] = conv_diff;
      end
      n_starts = n_starts + 1;
    end
    if (rst_n && eoc_irq) irq_cnt = irq_cnt + 1;
    if (rst_n && dma_req) dma_cnt = dma_cnt + 1;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_read(input int ch, output logic v, output logic [11:0] d);
    @(negedge clk);
    rd_idx = 3'(ch);
    rd_en = 1'b1;
    #1;
    v = rd_valid;
    d = rd_data;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic clear_all();
    logic v;
    logic [11:0] d;
    for (int c = 0; c < 8; c++) do_read(c, v, d);
  endtask

  task automatic pulse_start();
    @(negedge clk);
    start_set = 1'b1;
    @(negedge clk);
    start_set = 1'b0;
  endtask

  task automatic wait_idle();
    for (int k = 0; k < 400 && start_bit; k++) @(negedge clk);
    repeat (LAT + 3) @(negedge clk);
  endtask

  task automatic reset_logs();
    @(negedge clk);
    #1;
    n_starts = 0;
    irq_cnt = 0;
    dma_cnt = 0;
  endtask

  task automatic run_vec(input int i);
    logic [1:0] m;
    logic dif, tw, ie, de;
    logic [7:0] msk;
    int n, k, lowest;
    logic v;
    logic [11:0] d;
    logic wrote;
    logic [2:0] es;
    {m, dif, tw, ie, de, msk} = VEC[i][17:4];
    n = int'(VEC[i][3:0]);
    clear_all();
    @(negedge clk);
    cfg_mode = m; cfg_diff = dif; cfg_twos = tw;
    cfg_irq_en = ie; cfg_dma_en = de; cfg_chan_mask = msk; cfg_en = 1'b1;
    reset_logs();
    pulse_start();
    #1;
    // R5 (reserved) and R11 (empty mask) reject; others accept
    check((n == 0) ? ((m == 2'b01) ? "R5 start flag" : "R11 start flag") : "R3 start flag",
          32'(start_bit), 32'(n > 0));
    wait_idle();
    check((m == 2'b00) ? "R2 conversion count" : "R3 conversion count",
          32'(n_starts), 32'(n));
    lowest = 8;
    for (int c = 7; c >= 0; c--) if (msk[c]) lowest = c;
    k = 0;
    if (n > 0) begin
      for (int c = 0; c < 8; c++) begin
        if (msk[c] && (m != 2'b00 || c == lowest)) begin
          es = dif ? 3'(c >> 1) : 3'(c);
          check(dif ? "R6 pair select" : "R3 ascending order", 32'(log_sel[k]), 32'(es));
          check("R6 diff flag", 32'(log_diff[k]), 32'(dif));
          k++;
        end
      end
    end
    check("R8 interrupt pulses", 32'(irq_cnt), (ie && !de) ? 32'(n) : 32'd0);
    check("R8 DMA pulses", 32'(dma_cnt), de ? 32'(n) : 32'd0);
    for (int c = 0; c < 8; c++) begin
      wrote = (n > 0) && msk[c] && (m != 2'b00 || c == lowest);
      do_read(c, v, d);
      check("R9 valid after scan", 32'(v), 32'(wrote));
      if (wrote) begin
        es = dif ? 3'(c >> 1) : 3'(c);
        check((dif && tw) ? "R7 signed store" : "R7 raw store",
              32'(d), 32'(expect_store(raw_of(es, dif), dif && tw)));
      end
    end
  endtask

  initial begin : watchdog
    #(5.0 * 150000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : main
    logic v;
    logic [11:0] d;
    int snap;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // Reset state
    check("R10 idle start pulse", 32'(conv_start), 32'd0);
    check("R2 start flag after reset", 32'(start_bit), 32'd0);
    check("R8 no pulses after reset", 32'(eoc_irq | dma_req), 32'd0);
    do_read(5, v, d);
    check("R9 valid after reset", 32'(v), 32'd0);

    // R1: disabled converter ignores a start request
    cfg_en = 1'b0; cfg_mode = 2'b10; cfg_chan_mask = 8'hFF;
    reset_logs();
    pulse_start();
    #1;
    check("R1 start flag while disabled", 32'(start_bit), 32'd0);
    repeat (20) @(negedge clk);
    check("R1 no conversion while disabled", 32'(n_starts), 32'd0);

    // Table-driven scenarios
    for (int i = 0; i < NV; i++) run_vec(i);

    // R9: read-to-clear on a single result
    clear_all();
    @(negedge clk);
    cfg_en = 1'b1; cfg_mode = 2'b00; cfg_diff = 1'b0; cfg_twos = 1'b0;
    cfg_irq_en = 1'b0; cfg_dma_en = 1'b0; cfg_chan_mask = 8'h08;
    pulse_start();
    wait_idle();
    do_read(3, v, d);
    check("R9 valid set by write", 32'(v), 32'd1);
    do_read(3, v, d);
    check("R9 valid cleared by read", 32'(v), 32'd0);
    check("R9 data kept after read", 32'(d), 32'(raw_of(3'd3, 1'b0)));

    // R4: continuous scan wraps, then stops cleanly on clear
    clear_all();
    @(negedge clk);
    cfg_mode = 2'b11; cfg_chan_mask = 8'h06; cfg_irq_en = 1'b1;
    reset_logs();
    pulse_start();
    for (int k = 0; k < 200 && n_starts < 5; k++) @(negedge clk);
    check("R4 wrap order 0", 32'(log_sel[0]), 32'd1);
    check("R4 wrap order 1", 32'(log_sel[1]), 32'd2);
    check("R4 wrap order 2", 32'(log_sel[2]), 32'd1);
    check("R4 wrap order 3", 32'(log_sel[3]), 32'd2);
    check("R4 wrap order 4", 32'(log_sel[4]), 32'd1);
    check("R4 still running", 32'(start_bit), 32'd1);
    @(negedge clk);
    start_clr = 1'b1;
    @(negedge clk);
    start_clr = 1'b0;
    #1;
    snap = n_starts;
    check("R4 flag cleared by stop", 32'(start_bit), 32'd0);
    repeat (30) @(negedge clk);
    check("R4 no start after stop", 32'(n_starts), 32'(snap));
    check("R4 in-flight result stored", 32'(irq_cnt), 32'(snap));
    do_read(1, v, d);
    check("R4 channel 1 stored", 32'(v), 32'd1);
    do_read(2, v, d);
    check("R4 channel 2 stored", 32'(v), 32'd1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule